// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits on the receive side of an optical line interface. It runs on the recovered bit clock. It takes the retimed serial stream one bit per clock and searches every bit position for the framing signature: the last two A1 bytes (0xF6) followed by the first A2 byte (0x28). When it finds the signature, it fixes the byte phase at that offset. From then on it presents whole bytes on an 8-bit output, together with a byte-rate clock and a frame pulse on the byte that carries the first A2.

Once the block is locked, the byte phase is frozen. A frame counter of the selected frame length predicts where the next frame pulse falls, so bit patterns in the payload that look like framing are ignored.

Downstream logic raises an out-of-frame input when it loses confidence in the alignment. That input, or a change of the rate-select input between the 3-column and 12-column frame, restarts the search.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While `rst_n` is low, `pout` is 0x00 and both `fp` and `byte_clk` are 0. The block leaves reset in the searching state.
- R2: While searching, the 24-bit sequence 0xF6 0xF6 0x28 (bits received MSB first) is recognised at any bit offset. On the clock edge that samples its last bit, `pout` becomes 0x28 and `fp` becomes 1. No frame pulse appears before this point.
- R3: After alignment, `pout` takes a new byte every 8 bit clocks. The earliest received bit is the MSB. `pout` and `fp` hold their values between byte updates.
- R4: `byte_clk` is 0 for the 4 bit clocks that start with each byte update and 1 for the following 4.
- R5: While locked, `fp` is 1 for exactly one byte. It recurs 2430 bytes after the previous pulse byte when `sts12_sel`=0, and 9720 bytes after it when `sts12_sel`=1.
- R6: While locked with `oof` low, framing-like patterns in the payload, whether byte-aligned or not, change neither the byte phase nor the frame pulse position.
- R7: While locked with `oof` low, a bit slip in the stream does not move the byte phase. The frame pulse stays where the counter predicts it.
- R8: A high `oof` level for at least one bit clock drops the lock. No predicted pulse is issued until the signature is found again, and the block then realigns to the new bit offset.
- R9: `sts12_sel`=1 selects the 9720-byte frame and `sts12_sel`=0 selects the 2430-byte frame. Any change of `sts12_sel` drops the lock and starts a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Retimed serial data, one bit per clock |
| oof | input | 1 | Out-of-frame request from downstream; restarts the search |
| sts12_sel | input | 1 | 1 selects the 12-column frame, 0 the 3-column frame |
| byte_clk | output | 1 | Byte-rate clock, low in the first half of each byte slot |
| pout | output | 8 | Aligned parallel byte, MSB received first |
| fp | output | 1 | Frame pulse, high for the byte carrying the first A2 |

## Verification
A wrong bit phase shows on `pout` at the next byte update as a byte mixing bits of two neighbours. For example, a 3-bit slip turns the first A2 into 0xC5. A corrupted frame counter or lock flag becomes visible only at the next frame boundary: the pulse is missing or misplaced, or it lands on a payload byte. For this reason the checks run across whole frames of 2430 or 9720 bytes. Failing to drop the lock on `oof` or on a rate change shows up one frame later, as a pulse at the old count position instead of on the new 0x28.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
  localparam logic [7:0] A1_VAL = 8'hF6;
  localparam logic [7:0] A2_VAL = 8'h28;

  typedef logic [2:0] bit_phase_t;

  // bytes in one frame of an N-column-group signal
  function automatic int unsigned frame_bytes(input int unsigned rows,
                                              input int unsigned cols_sts1,
                                              input int unsigned n);
    return rows * cols_sts1 * n;
  endfunction

  // bit phase advance: restart at a byte boundary, else count up
  function automatic bit_phase_t next_phase(input bit_phase_t ph, input logic restart);
    return restart ? bit_phase_t'(0) : bit_phase_t'(ph + 3'd1);
  endfunction
endpackage

// File: rtl/sfa_window.sv
`timescale 1ns/1ps
module sfa_window #(
  parameter int unsigned N_A1 = 2,
  parameter int unsigned N_A2 = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  output logic [7:0] last_byte,
  output logic       hit
);
  import sfa_pkg::*;
  localparam int unsigned NB = N_A1 + N_A2;
  localparam int unsigned W  = 8 * NB;

  function automatic logic [W-1:0] build_pattern();
    logic [W-1:0] p;
    p = '0;
    for (int k = 0; k < int'(NB); k++)
      p[W-1-8*k -: 8] = (k < int'(N_A1)) ? A1_VAL : A2_VAL;
    return p;
  endfunction

  localparam logic [W-1:0] PATTERN = build_pattern();

  logic [W-2:0] hist;
  logic [W-1:0] win;

  assign win       = {hist, ser_in};
  assign hit       = (win == PATTERN);
  assign last_byte = win[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= win[W-2:0];
  end
endmodule

// File: rtl/sfa_phase.sv
`timescale 1ns/1ps
module sfa_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  output logic byte_evt,
  output logic byte_clk
);
  import sfa_pkg::*;
  bit_phase_t ph;
  bit_phase_t ph_nx;

  assign byte_evt = (ph == 3'd7) || realign;
  assign ph_nx    = next_phase(ph, byte_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      byte_clk <= 1'b0;
    end else begin
      ph       <= ph_nx;
      byte_clk <= ph_nx[2];
    end
  end

  // R4: clock low right after a byte update, high from the fifth bit
  a_r4_clk_low_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |=> !byte_clk);
  a_r4_clk_high_mid_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'd3 && !realign) |=> byte_clk);
  // R3: without realignment the phase steps once per bit
  a_r3_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!realign && ph != 3'd7) |=> (ph == $past(ph) + 3'd1));
endmodule

// File: rtl/sfa_sync.sv
`timescale 1ns/1ps
module sfa_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic oof,
  input  logic sts12_sel,
  input  logic hit,
  output logic hunt,
  output logic realign,
  output logic mode_q
);
  logic in_sync;
  logic mode_chg;

  assign mode_chg = (sts12_sel != mode_q);
  assign hunt     = !in_sync || oof || mode_chg;
  assign realign  = hunt && hit && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sync <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= sts12_sel;
      if (mode_chg)     in_sync <= 1'b0;
      else if (realign) in_sync <= 1'b1;
      else if (oof)     in_sync <= 1'b0;
    end
  end

  // R8: an out-of-frame request without a fresh match drops the lock
  a_r8_oof_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (oof && !realign) |=> !in_sync);
  // R9: a rate change forces searching and blocks realignment that cycle
  a_r9_mode_change_hunts: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sts12_sel) |-> (hunt && !realign));
  // R6: lock is kept whatever the data does
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && !oof && $stable(sts12_sel)) |=> in_sync);
endmodule

// File: rtl/sfa_framectr.sv
`timescale 1ns/1ps
module sfa_framectr #(
  parameter int unsigned FB_HI = 9720,
  parameter int unsigned FB_LO = 2430
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_evt,
  input  logic realign,
  input  logic mode_hi,
  output logic frame_start
);
  localparam int unsigned CW = $clog2(FB_HI + 1);

  logic [CW-1:0] fcnt;
  logic [CW-1:0] last;

  assign last        = mode_hi ? CW'(FB_HI - 1) : CW'(FB_LO - 1);
  assign frame_start = (fcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fcnt <= '0;
    else if (byte_evt) begin
      if (realign)           fcnt <= CW'(1);
      else if (fcnt >= last) fcnt <= '0;
      else                   fcnt <= fcnt + CW'(1);
    end
  end

  // R5: counter never leaves the longest frame
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(FB_HI - 1));
  // R5: the byte after the matched A2 is position one
  a_r5_realign_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && realign) |=> (fcnt == CW'(1)));
endmodule

// File: rtl/sonet_frame_aligner.sv
`timescale 1ns/1ps
module sonet_frame_aligner #(
  parameter int unsigned ROWS      = 9,
  parameter int unsigned COLS_STS1 = 90,
  parameter int unsigned N_HI      = 12,
  parameter int unsigned N_LO      = 3,
  parameter int unsigned MATCH_A1  = 2,
  parameter int unsigned MATCH_A2  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       oof,
  input  logic       sts12_sel,
  output logic       byte_clk,
  output logic [7:0] pout,
  output logic       fp
);
  import sfa_pkg::*;
  localparam int unsigned FB_HI = frame_bytes(ROWS, COLS_STS1, N_HI);
  localparam int unsigned FB_LO = frame_bytes(ROWS, COLS_STS1, N_LO);

  logic [7:0] last_byte;
  logic       hit;
  logic       hunt;
  logic       realign;
  logic       mode_q;
  logic       byte_evt;
  logic       frame_start;

  sfa_window #(.N_A1(MATCH_A1), .N_A2(MATCH_A2)) u_window (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .last_byte(last_byte), .hit(hit));

  sfa_sync u_sync (
    .clk(clk), .rst_n(rst_n), .oof(oof), .sts12_sel(sts12_sel), .hit(hit),
    .hunt(hunt), .realign(realign), .mode_q(mode_q));

  sfa_phase u_phase (
    .clk(clk), .rst_n(rst_n), .realign(realign),
    .byte_evt(byte_evt), .byte_clk(byte_clk));

  sfa_framectr #(.FB_HI(FB_HI), .FB_LO(FB_LO)) u_framectr (
    .clk(clk), .rst_n(rst_n), .byte_evt(byte_evt), .realign(realign),
    .mode_hi(mode_q), .frame_start(frame_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pout <= '0;
      fp   <= 1'b0;
    end else if (byte_evt) begin
      pout <= last_byte;
      fp   <= realign || (!hunt && frame_start);
    end
  end

  // R2: a match while searching puts A2 on the output with the pulse
  a_r2_match_marks_a2: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (fp && pout == A2_VAL));
  // R3: outputs hold between byte updates
  a_r3_hold_between_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_evt |=> ($stable(pout) && $stable(fp)));
  // R5: pulse lasts a single byte
  a_r5_single_byte_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && fp && !realign) |=> !fp);
  // R6: while locked, no pulse off the predicted position
  a_r6_no_pulse_off_count: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && !hunt && !frame_start) |=> !fp);
endmodule

// File: tb/test_sonet_frame_aligner.sv
`timescale 1ns/1ps
module test_sonet_frame_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       oof = 1'b0;
  logic       sts12_sel = 1'b0;
  logic       byte_clk;
  logic [7:0] pout;
  logic       fp;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] got;
  logic gfp, bclk_mid, bclk_end;

  sonet_frame_aligner i_sonet_frame_aligner (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .oof(oof),
    .sts12_sel(sts12_sel), .byte_clk(byte_clk), .pout(pout), .fp(fp));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // frame content: n A1, n A2, payload free of long runs of ones
  function automatic logic [7:0] fbyte(input int n, input int idx, input bit decoy);
    logic [7:0] v;
    if (idx < n) return 8'hF6;
    if (idx < 2*n) return 8'h28;
    if (decoy) begin
      case (idx)
        600: return 8'h1E;   // signature shifted by 3 bits
        601: return 8'hDE;
        602: return 8'hC5;
        603: return 8'h00;
        1200: return 8'hF6;  // byte-aligned signature
        1201: return 8'hF6;
        1202: return 8'h28;
        default: ;
      endcase
    end
    v = 8'(idx*37 + 11);
    return v & 8'h55;
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      if (i == 3) bclk_mid = byte_clk;
      ser_in = b[i];
    end
    @(posedge clk);
    #5;
    got = pout; gfp = fp; bclk_end = byte_clk;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(pout == 8'h00, "R1", "pout in reset", pout, 0);
    check(fp == 1'b0, "R1", "fp in reset", fp, 0);
    check(byte_clk == 1'b0, "R1", "byte_clk in reset", byte_clk, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire();
    int pre = 0, bad_b = 0, bad_fp = 0;
    repeat (13) drive_bit(1'b0);
    for (int idx = 0; idx < 2430; idx++) begin
      send_byte(fbyte(3, idx, 1'b0));
      if (idx < 3 && gfp) pre++;
      if (idx == 3) begin
        check(gfp == 1'b1, "R2", "fp on first A2", gfp, 1);
        check(got == 8'h28, "R2", "byte on first A2", got, 8'h28);
      end
      if (idx == 4) begin
        check(bclk_mid == 1'b1, "R4", "byte_clk mid byte", bclk_mid, 1);
        check(bclk_end == 1'b0, "R4", "byte_clk after update", bclk_end, 0);
      end
      if (idx > 3) begin
        if (got != fbyte(3, idx, 1'b0)) bad_b++;
        if (gfp) bad_fp++;
      end
    end
    check(pre == 0, "R2", "pulses before signature", pre, 0);
    check(bad_b == 0, "R3", "misaligned bytes", bad_b, 0);
    check(bad_fp == 0, "R5", "extra pulses in frame", bad_fp, 0);
  endtask

  task automatic t_decoy();
    int bad_b = 0, bad_fp = 0;
    for (int idx = 0; idx < 2430; idx++) begin
      send_byte(fbyte(3, idx, 1'b1));
      if (idx == 3) begin
        check(gfp == 1'b1, "R5", "predicted pulse after 2430 bytes", gfp, 1);
        check(got == 8'h28, "R5", "predicted pulse byte", got, 8'h28);
      end else if (gfp) bad_fp++;
      if (got != fbyte(3, idx, 1'b1)) bad_b++;
    end
    check(bad_fp == 0, "R6", "pulses from payload decoys", bad_fp, 0);
    check(bad_b == 0, "R6", "bytes moved by decoys", bad_b, 0);
  endtask

  task automatic t_slip_oof();
    int bad_fp = 0;
    repeat (3) drive_bit(1'b0);
    for (int idx = 0; idx < 2430; idx++) begin
      if (idx == 100) oof = 1'b1;
      if (idx == 108) oof = 1'b0;
      send_byte(fbyte(3, idx, 1'b0));
      if (idx == 3) begin
        check(gfp == 1'b1, "R7", "pulse stays on count after slip", gfp, 1);
        check(got == 8'hC5, "R7", "old phase kept after slip", got, 8'hC5);
      end else if (gfp) bad_fp++;
    end
    check(bad_fp == 0, "R8", "pulses while searching", bad_fp, 0);
  endtask

  task automatic t_relock_mode();
    int bad_b = 0, bad_fp = 0;
    for (int idx = 0; idx < 2430; idx++) begin
      if (idx == 40) sts12_sel = 1'b1;
      send_byte(fbyte(3, idx, 1'b0));
      if (idx == 3) begin
        check(gfp == 1'b1, "R8", "pulse after new search", gfp, 1);
        check(got == 8'h28, "R8", "realigned A2", got, 8'h28);
      end else if (gfp) bad_fp++;
      if (idx > 3 && idx < 40 && got != fbyte(3, idx, 1'b0)) bad_b++;
    end
    check(bad_b == 0, "R8", "bytes at new offset", bad_b, 0);
    check(bad_fp == 0, "R9", "pulses after rate change", bad_fp, 0);
  endtask

  task automatic t_sts12();
    int bad_b = 0, bad_fp = 0;
    for (int idx = 0; idx < 9720; idx++) begin
      send_byte(fbyte(12, idx, 1'b0));
      if (idx == 12) begin
        check(gfp == 1'b1, "R9", "pulse on 12-column A2", gfp, 1);
        check(got == 8'h28, "R9", "12-column A2 byte", got, 8'h28);
      end else if (gfp) bad_fp++;
      if (idx > 12 && idx < 60 && got != fbyte(12, idx, 1'b0)) bad_b++;
    end
    check(bad_fp == 0, "R9", "pulses inside 9720-byte frame", bad_fp, 0);
    check(bad_b == 0, "R9", "12-column payload bytes", bad_b, 0);
    bad_fp = 0;
    for (int idx = 0; idx < 13; idx++) begin
      send_byte(fbyte(12, idx, 1'b0));
      if (idx == 12) check(gfp == 1'b1, "R5", "pulse 9720 bytes later", gfp, 1);
      else if (gfp) bad_fp++;
    end
    check(bad_fp == 0, "R5", "early pulses in next 12-column frame", bad_fp, 0);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_decoy();
    t_slip_oof();
    t_relock_mode();
    t_sts12();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule